// File: doc/BRIEF.md
# Wireless MAC Statistics Counter Bank

This block keeps four event counters for a wireless MAC: transmit-request handshakes that succeeded, those that failed, missing acknowledgements, and frames that failed their checksum. The receive and transmit logic sends one-cycle pulses on `evt_i`, one bit per counter. Software reads a counter through a small read port, and the read resets that counter to zero. No separate step is needed to restart the count.

A four-bit control register acts on every counter at once. Bit 1 holds all counters still. Bit 2 zeroes all counters. Bit 3 adds one to every counter. Bit 0 is a warning bit that software can set to force the interrupt. The interrupt output `irq_o` stays high while any counter is at or above a fixed threshold (0xC000 at the default width) or while the warning bit is set. Counters stop at all-ones and never wrap.

Top module: `mib_stat_bank`

## Requirements
- R1: After reset all counters are zero, `rd_data_o`, `rd_valid_o`, `irq_o` and `ctl_rdata_o` are zero.
- R2: A pulse on `evt_i[k]` adds one to counter k one cycle later. Index 0 counts handshake successes, 1 handshake failures, 2 missing acknowledgements and 3 checksum failures.
- R3: A read (`rd_en_i` high with `rd_sel_i` = k) puts counter k's value on `rd_data_o` with `rd_valid_o` high in the next cycle, and leaves counter k at zero.
- R4: When a read and an increment hit the same counter in one cycle, the read returns the old value and the counter becomes 1.
- R5: While control bit 1 (freeze) is stored as 1, event pulses and the increment-all strobe change no counter, but reads still return the value and zero the counter. Freeze takes effect from the cycle after its write.
- R6: A control write with bit 2 set zeroes every counter in the next cycle. This takes priority over any event or strobe in the same cycle. The bit is not stored.
- R7: A control write with bit 3 set adds one to every counter that is not frozen. An event pulse on the same counter in that cycle still adds only one in total. The bit is not stored.
- R8: `irq_o` is high while any counter is at or above THRESH, and it falls once every such counter has been read or cleared and the warning bit is 0.
- R9: Control bit 0 (warning) stores the value written, and `irq_o` is high while it is 1.
- R10: A counter at all-ones stays at all-ones on further increments.
- R11: `ctl_rdata_o` shows the stored warning bit at bit 0 and the freeze bit at bit 1. Bits 2 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CNT | One-cycle event pulses, one per counter |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control write data: warning, freeze, clear, increment-all |
| ctl_rdata_o | output | 4 | Stored control bits |
| rd_en_i | input | 1 | Counter read request |
| rd_sel_i | input | SEL_W | Index of the counter to read |
| rd_data_o | output | CNT_W | Value of the counter that was read |
| rd_valid_o | output | 1 | High the cycle after a read |
| irq_o | output | 1 | Threshold or warning interrupt |

## Verification
The bench uses an 8-bit, threshold-0xC0 build. For each counter it runs event counts from zero to thirty followed by a read, which shows whether the pulses reach the right counter and whether the read clears it. One counter is driven well past all-ones while `irq_o` is checked on every step, which pins down the exact threshold crossing and the saturation limit. Mixed patterns cover the cases where the priorities differ: read plus event, strobe plus event, clear plus event, and reads while frozen.

// File: rtl/mib_stat_pkg.sv
package mib_stat_pkg;

  localparam int CTL_W       = 4;
  localparam int CTL_WARN_B  = 0;
  localparam int CTL_FRZ_B   = 1;
  localparam int CTL_CLR_B   = 2;
  localparam int CTL_STB_B   = 3;

  // Decoded control state shared by all counter cells
  typedef struct packed {
    logic warn;    // stored warning bit
    logic freeze;  // stored freeze bit
    logic clr;     // one-cycle clear pulse
    logic stb;     // one-cycle increment-all pulse
  } ctl_cmd_t;

endpackage

// File: rtl/mib_ctl_reg.sv
module mib_ctl_reg
  import mib_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_cmd_t         cmd_o,
  output logic [CTL_W-1:0] rdata_o
);

  logic warn_q, warn_d;
  logic frz_q, frz_d;

  always_comb begin
    warn_d = warn_q;
    frz_d  = frz_q;
    if (wr_i) begin
      warn_d = wdata_i[CTL_WARN_B];
      frz_d  = wdata_i[CTL_FRZ_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      frz_q  <= 1'b0;
    end else if (wr_i) begin
      warn_q <= warn_d;
      frz_q  <= frz_d;
    end
  end

  always_comb begin
    cmd_o.warn   = warn_q;
    cmd_o.freeze = frz_q;
    cmd_o.clr    = wr_i & wdata_i[CTL_CLR_B];
    cmd_o.stb    = wr_i & wdata_i[CTL_STB_B];
    rdata_o      = '0;
    rdata_o[CTL_WARN_B] = warn_q;
    rdata_o[CTL_FRZ_B]  = frz_q;
  end

  // R9
  warn_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> warn_q == $past(wdata_i[CTL_WARN_B]));

  // R5
  frz_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(frz_q));

endmodule

// File: rtl/mib_cnt_cell.sv
module mib_cnt_cell #(
  parameter int               CNT_W  = 16,
  parameter logic [CNT_W-1:0] THRESH = 16'hC000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             stb_i,
  input  logic             frz_i,
  input  logic             clr_i,
  input  logic             rd_hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_thr_o
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             inc, cnt_en;

  always_comb begin
    inc    = ~frz_i & (evt_i | stb_i);
    cnt_en = clr_i | rd_hit_i | inc;
    cnt_d  = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (rd_hit_i)
      cnt_d = inc ? ONE : '0;
    else if (inc && (cnt_q != FULL))
      cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign at_thr_o = (cnt_q >= THRESH);

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && !clr_i && !rd_hit_i) |=> cnt_q == FULL);

  // R5
  frz_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_i && !clr_i && !rd_hit_i) |=> $stable(cnt_q));

  // R4
  rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_i && !clr_i && !frz_i && (evt_i || stb_i)) |=> cnt_q == ONE);

endmodule

// File: rtl/mib_rd_port.sv
module mib_rd_port #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 16,
  parameter int SEL_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en_i,
  input  logic [SEL_W-1:0]              rd_sel_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all_i,
  output logic [NUM_CNT-1:0]            hit_o,
  output logic [CNT_W-1:0]              rd_data_o,
  output logic                          rd_valid_o
);

  logic [CNT_W-1:0] data_q, data_d;
  logic             vld_q;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_hit
    assign hit_o[g] = rd_en_i && (rd_sel_i == SEL_W'(g));
  end

  always_comb begin
    data_d = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (hit_o[k]) data_d = cnt_all_i[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (rd_en_i)
      data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vld_q <= 1'b0;
    else
      vld_q <= rd_en_i;
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = vld_q;

  // R3
  rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> vld_q);

  // R3
  hit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o));

endmodule

// File: rtl/mib_stat_bank.sv
module mib_stat_bank
  import mib_stat_pkg::*;
#(
  parameter int               NUM_CNT = 4,
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] THRESH  = 16'hC000,
  parameter int               SEL_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               ctl_wr_i,
  input  logic [3:0]         ctl_wdata_i,
  output logic [3:0]         ctl_rdata_o,
  input  logic               rd_en_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               rd_valid_o,
  output logic               irq_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctl_cmd_t                      cmd;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0]            hit;
  logic [NUM_CNT-1:0]            at_thr;

  mib_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .cmd_o   (cmd),
    .rdata_o (ctl_rdata_o)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    mib_cnt_cell #(.CNT_W(CNT_W), .THRESH(THRESH)) u_cell (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .evt_i    (evt_i[g]),
      .stb_i    (cmd.stb),
      .frz_i    (cmd.freeze),
      .clr_i    (cmd.clr),
      .rd_hit_i (hit[g]),
      .cnt_o    (cnt_all[g]),
      .at_thr_o (at_thr[g])
    );
  end

  mib_rd_port #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .cnt_all_i  (cnt_all),
    .hit_o      (hit),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  always_comb irq_o = (|at_thr) | cmd.warn;

  // R6
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd.clr |=> (cnt_all == '0));

  // R8
  irq_clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_wr_i && ctl_wdata_i[CTL_CLR_B] && !ctl_wdata_i[CTL_WARN_B]) |=> !irq_o);

endmodule

// File: tb/sim_mib_stat_bank.sv
`timescale 1ns/1ps
module sim_mib_stat_bank;

  localparam int         NC = 4;
  localparam int         CW = 8;
  localparam logic [7:0] TH = 8'hC0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt = '0;
  logic       wr = 1'b0;
  logic [3:0] wd = '0;
  logic [3:0] crd;
  logic       rd = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] rdat;
  logic       rvld;
  logic       irq;

  int errs = 0;
  int chks = 0;
  int m [NC];
  bit mfrz = 0, mwarn = 0;

  always #4 clk = ~clk;

  mib_stat_bank #(.NUM_CNT(NC), .CNT_W(CW), .THRESH(TH)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ctl_wr_i(wr), .ctl_wdata_i(wd),
    .ctl_rdata_o(crd), .rd_en_i(rd), .rd_sel_i(sel), .rd_data_o(rdat),
    .rd_valid_o(rvld), .irq_o(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock cycle of stimulus; model follows the requirements
  task automatic step(input logic [3:0] e, input logic w, input logic [3:0] d,
                      input logic r, input logic [1:0] s, input string tag);
    int  old;
    bit  clr, stb, inc, any;
    @(negedge clk);
    evt = e; wr = w; wd = d; rd = r; sel = s;
    @(posedge clk);
    #1;
    old = m[s];
    clr = w && d[2];
    stb = w && d[3];
    for (int j = 0; j < NC; j++) begin
      inc = !mfrz && (e[j] || stb);
      if (clr) m[j] = 0;
      else if (r && s == j) m[j] = inc ? 1 : 0;
      else if (inc && m[j] != 255) m[j] = m[j] + 1;
    end
    if (w) begin mfrz = d[1]; mwarn = d[0]; end
    if (r) begin
      chk(rvld == 1'b1, tag, rvld, 1);
      chk(rdat == old[7:0], tag, rdat, old);
    end
    any = mwarn;
    for (int j = 0; j < NC; j++) if (m[j] >= TH) any = 1;
    chk(irq == any, "R8", irq, any);
    chk(crd == {2'b00, mfrz, mwarn}, "R11", crd, {mfrz, mwarn});
    evt = '0; wr = 0; wd = '0; rd = 0;
  endtask

  task automatic rdc(input int k, input string tag);
    step(4'h0, 0, 4'h0, 1, k[1:0], tag);
  endtask

  initial begin
    #1_000_000;
    errs++; chks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    int ns [5] = '{0, 1, 2, 7, 30};
    for (int j = 0; j < NC; j++) m[j] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk(irq == 0, "R1", irq, 0);
    chk(rvld == 0, "R1", rvld, 0);
    chk(rdat == 0, "R1", rdat, 0);
    chk(crd == 0, "R1", crd, 0);
    for (int k = 0; k < NC; k++) rdc(k, "R1");

    // R2 / R3 sweep of event counts per counter
    for (int k = 0; k < NC; k++)
      for (int n = 0; n < 5; n++) begin
        repeat (ns[n]) step(4'(1 << k), 0, 4'h0, 0, 2'd0, "R2");
        rdc(k, "R2");
        rdc(k, "R3");
      end

    // R4 read and increment in the same cycle
    repeat (3) step(4'b0010, 0, 4'h0, 0, 2'd0, "R4");
    step(4'b0010, 0, 4'h0, 1, 2'd1, "R4");
    rdc(1, "R4");

    // R5 freeze: events and strobe blocked, reads still clear
    repeat (4) step(4'b0100, 0, 4'h0, 0, 2'd0, "R5");
    step(4'h0, 1, 4'b0010, 0, 2'd0, "R5");
    repeat (3) step(4'hF, 0, 4'h0, 0, 2'd0, "R5");
    step(4'hF, 1, 4'b1010, 0, 2'd0, "R5");
    rdc(2, "R5");
    rdc(2, "R5");
    rdc(0, "R5");
    step(4'h0, 1, 4'b0000, 0, 2'd0, "R5");

    // R6 clear beats a simultaneous event
    repeat (5) step(4'hF, 0, 4'h0, 0, 2'd0, "R6");
    step(4'hF, 1, 4'b0100, 0, 2'd0, "R6");
    for (int k = 0; k < NC; k++) rdc(k, "R6");

    // R7 strobe, with and without a coincident event
    step(4'b0001, 1, 4'b1000, 0, 2'd0, "R7");
    step(4'h0, 1, 4'b1000, 0, 2'd0, "R7");
    step(4'b0110, 1, 4'b1000, 0, 2'd0, "R7");
    for (int k = 0; k < NC; k++) rdc(k, "R7");

    // R8 / R10 ramp counter 3 through threshold and past all-ones
    for (int n = 0; n < 260; n++) step(4'b1000, 0, 4'h0, 0, 2'd0, "R8");
    rdc(3, "R10");
    rdc(3, "R8");

    // R8 clear drops interrupt
    for (int n = 0; n < 200; n++) step(4'b0001, 0, 4'h0, 0, 2'd0, "R8");
    step(4'h0, 1, 4'b0100, 0, 2'd0, "R8");

    // R9 warning bit forces interrupt
    step(4'h0, 1, 4'b0001, 0, 2'd0, "R9");
    chk(irq == 1, "R9", irq, 1);
    step(4'h0, 1, 4'b0000, 0, 2'd0, "R9");
    chk(irq == 0, "R9", irq, 0);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

endmodule